// File: doc/BRIEF.md
# DMA Channel Bank Register Window

This block is the shared register front end for a bank of DMA channels. A 32-bit, word-access register port presents a 4 KB main window. Offsets below 0xF00 are cut into 256-byte slices, one per channel. The slice number picks the channel, and the low byte is passed on as the register offset inside that channel's register file. The block drives a one-hot select, a write flag, the offset and the write data to the channel bank. It returns the chosen channel's read data one cycle later, with a read-valid strobe.

The top of the main window holds two global registers. One is a channel-enable word that is fed to every channel. The other is a read-only summary with one interrupt bit per channel. Each channel raises and lowers its own bit through set and clear request lines. A second, auxiliary 256-byte window is chosen by a window-select input, and it always lands on the last channel. This lets that channel live at an address of its own in the system map. Any other high offset, and any access that is not a full word, reads as zero and changes nothing.

Top module: `dmadec_regwin`

## Requirements
- R1: While reset is held, and on the first cycle after it, `ch_enable` is all ones (0xFFFF for 16 channels), `irq_status` is 0 and `bus_rvalid` is 0.
- R2: A word access in the main window (`bus_aux`=0) at offset below 0xF00 asserts exactly the `ch_sel` bit numbered by offset bits 11:8 in the same cycle. It drives `ch_off` with offset bits 7:0, `ch_we` with `bus_we`, and `ch_wdata` with `bus_wdata`.
- R3: A word access in the auxiliary window (`bus_aux`=1) always selects channel 15 (the last channel), with `ch_off` equal to offset bits 7:0. Offset bits 11:8 are ignored.
- R4: A read request returns `bus_rdata` with `bus_rvalid` high for exactly one cycle, in the cycle after the request. The data is the selected channel's `ch_rdata` slice (channel c at bits 32c+31:32c) sampled in the request cycle. A write produces no `bus_rvalid`.
- R5: Offset 0xFF0 in the main window is the enable register. A write stores `bus_wdata[15:0]` and drives it on `ch_enable`. A read returns that value with bits 31:16 zero. No other access changes it.
- R6: Offset 0xFE0 in the main window reads `irq_status` in bits 15:0, with the upper bits zero. Writes to it have no effect.
- R7: `irq_status` bit c becomes 1 the cycle after `irq_set[c]` and stays set. It becomes 0 the cycle after `irq_clr[c]`. When both arrive in the same cycle, the clear wins.
- R8: Any other main-window offset at or above 0xF00 selects no channel. A read of it returns 0, and a write changes neither register.
- R9: Only `bus_size`=2'b10 (32-bit word) is a valid access. Any other size selects no channel, writes nothing, and on a read returns 0 with `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_aux | input | 1 | 1 = auxiliary last-channel window, 0 = main window |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size, 2'b10 = 32-bit word |
| bus_addr | input | 12 | Byte offset inside the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| ch_sel | output | 16 | One-hot channel select |
| ch_we | output | 1 | Write strobe toward the selected channel |
| ch_off | output | 8 | Register offset inside the channel slice |
| ch_wdata | output | 32 | Write data toward the channel |
| ch_rdata | input | 512 | Concatenated channel read data, channel c at bits 32c+31:32c |
| irq_set | input | 16 | Per-channel interrupt raise requests |
| irq_clr | input | 16 | Per-channel interrupt clear requests |
| ch_enable | output | 16 | Global channel enable bits |
| irq_status | output | 16 | Per-channel interrupt summary |

## Verification
The channel bank is modelled so that each channel's read data encodes both its own index and the offset it receives. A single read therefore shows whether the slice decode, the offset routing and the return mux agree. Reads are tried at the first, a middle and the last main-window slice, and in the auxiliary window with non-zero upper offset bits. This separates a decoder that uses bits 11:8 from one that ignores the window select. Reads and writes are also tried at both global offsets, at an unused high offset and with non-word sizes. These show whether the high-offset compare, the size qualification and the register write enables are each gated on their own. Interrupt raise and clear are driven alone and together on different channels, which exposes the priority and any cross-channel coupling.

// File: rtl/dmadec_pkg.sv
package dmadec_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int OFF_W   = 8;
    localparam int IDX_W   = ADDR_W - OFF_W;

    localparam logic [1:0]        SIZE_WORD   = 2'b10;
    localparam logic [ADDR_W-1:0] HIGH_BASE   = 12'hF00;
    localparam logic [ADDR_W-1:0] OFF_IRQSUM  = 12'hFE0;
    localparam logic [ADDR_W-1:0] OFF_ENABLE  = 12'hFF0;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CHAN = 2'd1,
        TGT_IRQ  = 2'd2,
        TGT_EN   = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] chan;
        logic [OFF_W-1:0] off;
    } dec_t;

    // Classify one access; nch is the number of channels present
    function automatic dec_t classify(input logic aux,
                                      input logic [1:0] size,
                                      input logic [ADDR_W-1:0] addr,
                                      input int nch);
        dec_t d;
        d.tgt  = TGT_NONE;
        d.chan = IDX_W'(nch - 1);
        d.off  = addr[OFF_W-1:0];
        if (size == SIZE_WORD) begin
            if (aux) begin
                d.tgt = TGT_CHAN;
            end else if (addr < HIGH_BASE) begin
                d.chan = addr[ADDR_W-1:OFF_W];
                if (int'(addr[ADDR_W-1:OFF_W]) < nch)
                    d.tgt = TGT_CHAN;
            end else if (addr == OFF_IRQSUM) begin
                d.tgt = TGT_IRQ;
            end else if (addr == OFF_ENABLE) begin
                d.tgt = TGT_EN;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/dmadec_addr_decode.sv
module dmadec_addr_decode
    import dmadec_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic              req,
    input  logic              aux,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [NCH-1:0]    sel,
    output logic              chan_we,
    output logic              en_we,
    output logic              rd_req
);

    always_comb begin
        dec = classify(aux, size, addr, NCH);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign sel[i] = req && (dec.tgt == TGT_CHAN) && (int'(dec.chan) == i);
    end

    assign chan_we = req && we && (dec.tgt == TGT_CHAN);
    assign en_we   = req && we && (dec.tgt == TGT_EN);
    assign rd_req  = req && !we;

endmodule

// File: rtl/dmadec_global_regs.sv
module dmadec_global_regs
    import dmadec_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_we,
    input  logic [NCH-1:0] en_wdata,
    input  logic [NCH-1:0] irq_set,
    input  logic [NCH-1:0] irq_clr,
    output logic [NCH-1:0] enable,
    output logic [NCH-1:0] irq_sum
);

    always_ff @(posedge clk) begin
        if (rst)
            enable <= '1;
        else if (en_we)
            enable <= en_wdata;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_irq
        always_ff @(posedge clk) begin
            if (rst)
                irq_sum[i] <= 1'b0;
            else if (irq_clr[i])
                irq_sum[i] <= 1'b0;
            else if (irq_set[i])
                irq_sum[i] <= 1'b1;
        end

        // R7
        irq_clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
            irq_clr[i] |=> !irq_sum[i]);

        // R7
        irq_set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
            (irq_set[i] && !irq_clr[i]) |=> irq_sum[i]);
    end

    // R5
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_we |=> $stable(enable));

endmodule

// File: rtl/dmadec_read_return.sv
module dmadec_read_return
    import dmadec_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_req,
    input  dec_t                  dec,
    input  logic [NCH*DATA_W-1:0] ch_rdata,
    input  logic [NCH-1:0]        enable,
    input  logic [NCH-1:0]        irq_sum,
    output logic [DATA_W-1:0]     rdata,
    output logic                  rvalid
);

    localparam int PAD_W = DATA_W - NCH;

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        unique case (dec.tgt)
            TGT_CHAN: rd_mux = ch_rdata[int'(dec.chan)*DATA_W +: DATA_W];
            TGT_IRQ:  rd_mux = {{PAD_W{1'b0}}, irq_sum};
            TGT_EN:   rd_mux = {{PAD_W{1'b0}}, enable};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_req;
            if (rd_req)
                rdata <= rd_mux;
        end
    end

    // R4
    rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rvalid);

    // R4
    rvalid_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rvalid);

endmodule

// File: rtl/dmadec_regwin.sv
module dmadec_regwin
    import dmadec_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_req,
    input  logic                  bus_aux,
    input  logic                  bus_we,
    input  logic [1:0]            bus_size,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    output logic [NCH-1:0]        ch_sel,
    output logic                  ch_we,
    output logic [OFF_W-1:0]      ch_off,
    output logic [DATA_W-1:0]     ch_wdata,
    input  logic [NCH*DATA_W-1:0] ch_rdata,
    input  logic [NCH-1:0]        irq_set,
    input  logic [NCH-1:0]        irq_clr,
    output logic [NCH-1:0]        ch_enable,
    output logic [NCH-1:0]        irq_status
);

    dec_t dec;
    logic en_we;
    logic rd_req;

    dmadec_addr_decode #(.NCH(NCH)) u_decode (
        .req     (bus_req),
        .aux     (bus_aux),
        .we      (bus_we),
        .size    (bus_size),
        .addr    (bus_addr),
        .dec     (dec),
        .sel     (ch_sel),
        .chan_we (ch_we),
        .en_we   (en_we),
        .rd_req  (rd_req)
    );

    assign ch_off   = dec.off;
    assign ch_wdata = bus_wdata;

    dmadec_global_regs #(.NCH(NCH)) u_globals (
        .clk      (clk),
        .rst      (rst),
        .en_we    (en_we),
        .en_wdata (bus_wdata[NCH-1:0]),
        .irq_set  (irq_set),
        .irq_clr  (irq_clr),
        .enable   (ch_enable),
        .irq_sum  (irq_status)
    );

    dmadec_read_return #(.NCH(NCH)) u_return (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .dec      (dec),
        .ch_rdata (ch_rdata),
        .enable   (ch_enable),
        .irq_sum  (irq_status),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid)
    );

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_sel));

    // R2
    main_slice_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_aux && bus_size == SIZE_WORD && bus_addr < HIGH_BASE)
        |-> $countones(ch_sel) == 1);

    // R3
    aux_last_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_aux && bus_size == SIZE_WORD) |-> ch_sel[NCH-1]);

    // R8
    high_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_aux && bus_addr >= HIGH_BASE) |-> ch_sel == '0);

    // R9
    bad_size_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_size != SIZE_WORD) |-> (ch_sel == '0 && !ch_we)
        ##1 $stable(ch_enable));

endmodule

// File: tb/dmadec_regwin_tb_top.sv
module dmadec_regwin_tb_top;
    import dmadec_pkg::*;

    localparam int NCH = 16;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  bus_req = 1'b0;
    logic                  bus_aux = 1'b0;
    logic                  bus_we = 1'b0;
    logic [1:0]            bus_size = 2'b10;
    logic [ADDR_W-1:0]     bus_addr = '0;
    logic [DATA_W-1:0]     bus_wdata = '0;
    logic [DATA_W-1:0]     bus_rdata;
    logic                  bus_rvalid;
    logic [NCH-1:0]        ch_sel;
    logic                  ch_we;
    logic [OFF_W-1:0]      ch_off;
    logic [DATA_W-1:0]     ch_wdata;
    logic [NCH*DATA_W-1:0] ch_rdata;
    logic [NCH-1:0]        irq_set = '0;
    logic [NCH-1:0]        irq_clr = '0;
    logic [NCH-1:0]        ch_enable;
    logic [NCH-1:0]        irq_status;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dmadec_regwin #(.NCH(NCH)) dut_i (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_aux(bus_aux),
        .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .ch_sel(ch_sel), .ch_we(ch_we), .ch_off(ch_off), .ch_wdata(ch_wdata),
        .ch_rdata(ch_rdata), .irq_set(irq_set), .irq_clr(irq_clr),
        .ch_enable(ch_enable), .irq_status(irq_status)
    );

    // Channel bank model: data tags channel index and received offset
    function automatic logic [31:0] chan_word(input int c, input logic [7:0] off);
        return {4'hD, 4'(c), 8'h5A, 8'h00, off};
    endfunction

    always_comb begin
        for (int c = 0; c < NCH; c++)
            ch_rdata[c*32 +: 32] = chan_word(c, ch_off);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start(input logic aux, input logic we, input logic [1:0] size,
                         input logic [11:0] addr, input logic [31:0] wdata);
        @(negedge clk);
        bus_req = 1'b1; bus_aux = aux; bus_we = we;
        bus_size = size; bus_addr = addr; bus_wdata = wdata;
        #1;
    endtask

    // Advance past the capturing edge; registered read data is then visible
    task automatic finish_cycle();
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        #1;
    endtask

    typedef struct packed {
        logic        aux;
        logic [1:0]  size;
        logic [11:0] addr;
        logic        chv;
        logic [3:0]  ch;
        logic [7:0]  off;
        logic [31:0] other;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'b10, 12'h000, 1'b1, 4'd0,  8'h00, 32'h0},           // R2 first slice
        '{1'b0, 2'b10, 12'h3A4, 1'b1, 4'd3,  8'hA4, 32'h0},           // R2 middle slice
        '{1'b0, 2'b10, 12'hE08, 1'b1, 4'd14, 8'h08, 32'h0},           // R2 last main slice
        '{1'b1, 2'b10, 12'h010, 1'b1, 4'd15, 8'h10, 32'h0},           // R3
        '{1'b1, 2'b10, 12'hE3C, 1'b1, 4'd15, 8'h3C, 32'h0},           // R3 upper bits ignored
        '{1'b0, 2'b10, 12'hF00, 1'b0, 4'd0,  8'h00, 32'h0},           // R8
        '{1'b0, 2'b10, 12'hFFC, 1'b0, 4'd0,  8'hFC, 32'h0},           // R8
        '{1'b0, 2'b10, 12'hFF0, 1'b0, 4'd0,  8'hF0, 32'h0000FFFF},    // R5 reset value
        '{1'b0, 2'b10, 12'hFE0, 1'b0, 4'd0,  8'hE0, 32'h0},           // R6
        '{1'b0, 2'b01, 12'h504, 1'b0, 4'd0,  8'h04, 32'h0}            // R9
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 enable in reset", 32'(ch_enable), 32'h0000FFFF);
        chk("R1 irq in reset", 32'(irq_status), 32'h0);
        chk("R1 rvalid in reset", 32'(bus_rvalid), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 enable after reset", 32'(ch_enable), 32'h0000FFFF);

        // Vector table: reads through every path
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] exp_sel;
            logic [31:0] exp_rd;
            exp_sel = VECS[v].chv ? (32'h1 << VECS[v].ch) : 32'h0;
            exp_rd  = VECS[v].chv ? chan_word(int'(VECS[v].ch), VECS[v].off)
                                  : VECS[v].other;
            start(VECS[v].aux, 1'b0, VECS[v].size, VECS[v].addr, 32'h0);
            chk($sformatf("R2/R3/R8/R9 sel vec%0d", v), 32'(ch_sel), exp_sel);
            if (VECS[v].chv)
                chk($sformatf("R2/R3 offset vec%0d", v), 32'(ch_off), 32'(VECS[v].off));
            chk($sformatf("R2 no write vec%0d", v), 32'(ch_we), 32'h0);
            finish_cycle();
            chk($sformatf("R4 rvalid vec%0d", v), 32'(bus_rvalid), 32'h1);
            chk($sformatf("R4 rdata vec%0d", v), bus_rdata, exp_rd);
        end
        @(negedge clk);
        chk("R4 rvalid single pulse", 32'(bus_rvalid), 32'h0);

        // R2 channel write path, R4 no rvalid on write
        start(1'b0, 1'b1, 2'b10, 12'h718, 32'hDEADBEEF);
        chk("R2 write sel", 32'(ch_sel), 32'h0000_0080);
        chk("R2 write we", 32'(ch_we), 32'h1);
        chk("R2 write off", 32'(ch_off), 32'h18);
        chk("R2 write data", ch_wdata, 32'hDEADBEEF);
        finish_cycle();
        chk("R4 no rvalid on write", 32'(bus_rvalid), 32'h0);

        // R5 enable write and readback
        start(1'b0, 1'b1, 2'b10, 12'hFF0, 32'h1234A5C3);
        chk("R5 enable write no sel", 32'(ch_sel), 32'h0);
        finish_cycle();
        chk("R5 enable port", 32'(ch_enable), 32'h0000A5C3);
        start(1'b0, 1'b0, 2'b10, 12'hFF0, 32'h0);
        finish_cycle();
        chk("R5 enable readback", bus_rdata, 32'h0000A5C3);

        // R8 write to unused high offset, R9 non-word write to enable
        start(1'b0, 1'b1, 2'b10, 12'hF40, 32'h00000000);
        chk("R8 unused write no sel", 32'(ch_sel), 32'h0);
        finish_cycle();
        start(1'b0, 1'b1, 2'b00, 12'hFF0, 32'h00000000);
        chk("R9 byte write no we", 32'(ch_we), 32'h0);
        finish_cycle();
        start(1'b1, 1'b1, 2'b01, 12'h000, 32'h0);
        chk("R9 aux half write no sel", 32'(ch_sel), 32'h0);
        finish_cycle();
        chk("R8/R9 enable untouched", 32'(ch_enable), 32'h0000A5C3);

        // R7 interrupt set / clear
        @(negedge clk);
        irq_set = 16'h0020;
        @(negedge clk);
        irq_set = '0;
        chk("R7 set bit5", 32'(irq_status), 32'h0020);
        @(negedge clk);
        chk("R7 sticky bit5", 32'(irq_status), 32'h0020);
        irq_set = 16'h0220;
        irq_clr = 16'h0020;
        @(negedge clk);
        irq_set = '0;
        irq_clr = '0;
        chk("R7 clear wins, other channel set", 32'(irq_status), 32'h0200);

        // R6 read summary, write ignored
        start(1'b0, 1'b0, 2'b10, 12'hFE0, 32'h0);
        finish_cycle();
        chk("R6 irq read", bus_rdata, 32'h00000200);
        start(1'b0, 1'b1, 2'b10, 12'hFE0, 32'hFFFFFFFF);
        finish_cycle();
        chk("R6 irq write ignored", 32'(irq_status), 32'h0200);
        start(1'b0, 1'b0, 2'b10, 12'hFE0, 32'h0);
        finish_cycle();
        chk("R6 irq read after write", bus_rdata, 32'h00000200);

        irq_clr = 16'h0200;
        @(negedge clk);
        irq_clr = '0;
        chk("R7 clear bit9", 32'(irq_status), 32'h0);

        // R1 reset again restores enable
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 enable after second reset", 32'(ch_enable), 32'h0000FFFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule